// File: doc/BRIEF.md
# Asynchronous serial receiver with per-character error flags

This block turns an asynchronous serial line into characters of 5 to 9 data bits. Each bit is oversampled 16 times, or 8 times in fast mode, and the line is sampled at the centre of every bit. Received characters go into a two-entry buffer. A holding register stands behind the buffer and acts as a third stage. Every character carries its own frame-error, parity-error and overrun flags. The flags appear at the read port together with that character and advance with it when it is read.

The host reads the character at the head of the buffer through a small read port. The ninth bit and the three flags are visible without side effects. The read strobe pops the entry. A receive-complete level and a maskable interrupt tell the host when the buffer holds data. In multiprocessor mode, data frames are dropped before they enter the buffer, so only address frames reach the host. Clearing the enable aborts reception and empties every stage.

Top module: `sio_rx`

## Requirements
- R1: After reset, rx_done_o and irq_o are 0.
- R2: A frame is a low start bit, then char_bits_i data bits (5 to 9, values outside that range are clamped), least significant bit first, then an optional parity bit, then a stop bit. rdata_o carries data bits 7:0 with unused upper bits at 0, and bit9_o carries the ninth data bit.
- R3: One bit lasts 16*(div_i+1) clock cycles, or 8*(div_i+1) when dbl_speed_i is 1.
- R4: Each bit value is the majority of oversampling ticks 7, 8 and 9 (16x) or 3, 4 and 5 (8x). A start bit whose majority is high is rejected, so a short low glitch produces no character.
- R5: par_mode_i 2'b10 selects even parity and 2'b11 odd parity; other values mean no parity bit. parity_err_o is 1 for a character only if parity was enabled when its start bit arrived and the received parity bit did not match.
- R6: frame_err_o is 1 exactly when the sampled stop bit of the head character was 0. Only one stop bit is checked.
- R7: The buffer holds two characters in arrival order, and a holding register keeps a third. rd_lo_i pops the head, and all flags move with their own character.
- R8: If a start bit is confirmed while the buffer is full and the holding register is occupied, the held character gets overrun_o set, and the frame that follows is discarded.
- R9: With mpc_en_i at 1, every completed frame whose ninth data bit is 0 is discarded.
- R10: With rx_en_i at 0, the receiver is idle, and the buffer and holding register become empty one cycle later.
- R11: rx_done_o is 1 whenever the buffer is non-empty, and irq_o equals rx_done_o AND rx_irq_en_i.
- R12: bit9_o, rdata_o and the flags can be sampled for any number of cycles without changing the buffer; only rd_lo_i removes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receiver enable; low flushes |
| dbl_speed_i | input | 1 | 8x oversampling instead of 16x |
| div_i | input | DIV_W | Oversampling tick divisor minus one |
| char_bits_i | input | 4 | Data bits per character, 5 to 9 |
| par_mode_i | input | 2 | 2'b10 even, 2'b11 odd, else none |
| mpc_en_i | input | 1 | Drop frames with ninth bit 0 |
| rx_irq_en_i | input | 1 | Interrupt enable |
| rd_lo_i | input | 1 | Read strobe; pops the head entry |
| rdata_o | output | 8 | Head character bits 7:0 |
| bit9_o | output | 1 | Head character ninth bit |
| frame_err_o | output | 1 | Head character frame error |
| parity_err_o | output | 1 | Head character parity error |
| overrun_o | output | 1 | Head character overrun flag |
| rx_done_o | output | 1 | Buffer non-empty |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench uses the default DEPTH of 2, so four back-to-back frames are enough to fill the buffer and the holding register and to raise an overrun. It exercises the block with div_i values 0 and 2 and with both oversampling rates. With div_i at 0, one bit lasts only 8 or 16 cycles. This keeps every parity, frame-error, multiprocessor and flush case short, while the divisor and fast-mode paths are still covered.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  localparam int unsigned DATA_W   = 9;
  localparam int unsigned OSR_STD  = 16;
  localparam int unsigned CNT_W    = $clog2(OSR_STD);
  localparam int unsigned MIN_BITS = 5;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fe;
    logic              pe;
    logic              ovr;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/sio_rx_tick.sv
module sio_rx_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q >= div_i) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;

  assign tick_o = en_i && (cnt_q >= div_i);

  // R3: a non-zero divisor spaces ticks apart
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && en_i) |=> !tick_o);
endmodule

// File: rtl/sio_rx_deser.sv
module sio_rx_deser
  import sio_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       dbl_i,
  input  logic [3:0] char_bits_i,
  input  logic [1:0] par_mode_i,
  output logic       start_ok_o,
  output logic       done_o,
  output rx_char_t   char_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        bit_idx_q;
  logic [3:0]        nbits_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        vote_q;
  logic              par_en_q, par_odd_q, par_bit_q, dbl_q;
  logic [3:0]        nbits_eff;
  logic [CNT_W-1:0]  osr_last, mid_hi;
  logic              maj, par_exp;

  assign nbits_eff = (char_bits_i < 4'(MIN_BITS)) ? 4'(MIN_BITS) :
                     (char_bits_i > 4'(DATA_W))   ? 4'(DATA_W)   : char_bits_i;
  assign osr_last  = dbl_q ? CNT_W'(7) : CNT_W'(15);
  // last of the three centre samples
  assign mid_hi    = dbl_q ? CNT_W'(5) : CNT_W'(9);
  assign maj       = (vote_q[1] & vote_q[0]) | (vote_q[1] & rxd_i) | (vote_q[0] & rxd_i);
  assign par_exp   = (^data_q) ^ par_odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bit_idx_q  <= '0;
      nbits_q    <= 4'(MIN_BITS);
      data_q     <= '0;
      vote_q     <= 2'b11;
      par_en_q   <= 1'b0;
      par_odd_q  <= 1'b0;
      par_bit_q  <= 1'b0;
      dbl_q      <= 1'b0;
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      char_o     <= '0;
    end else begin
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        vote_q <= {vote_q[0], rxd_i};
        if (state_q == ST_IDLE) begin
          if (!rxd_i) begin
            state_q   <= ST_START;
            cnt_q     <= CNT_W'(1);
            data_q    <= '0;
            nbits_q   <= nbits_eff;
            par_en_q  <= par_mode_i[1];
            par_odd_q <= par_mode_i[0];
            dbl_q     <= dbl_i;
          end
        end else begin
          cnt_q <= (cnt_q == osr_last) ? '0 : cnt_q + 1'b1;
          if (cnt_q == mid_hi) begin
            case (state_q)
              ST_START: if (maj) state_q <= ST_IDLE;
                        else     start_ok_o <= 1'b1;
              ST_DATA:  data_q <= data_q | (DATA_W'(maj) << bit_idx_q);
              ST_PAR:   par_bit_q <= maj;
              ST_STOP: begin
                state_q     <= ST_IDLE;
                done_o      <= 1'b1;
                char_o.data <= data_q;
                char_o.fe   <= ~maj;
                char_o.pe   <= par_en_q && (par_bit_q != par_exp);
                char_o.ovr  <= 1'b0;
              end
              default: ;
            endcase
          end
          if (cnt_q == osr_last) begin
            case (state_q)
              ST_START: begin
                state_q   <= ST_DATA;
                bit_idx_q <= '0;
              end
              ST_DATA:
                if (bit_idx_q == nbits_q - 4'd1) state_q <= par_en_q ? ST_PAR : ST_STOP;
                else                             bit_idx_q <= bit_idx_q + 4'd1;
              ST_PAR:  state_q <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R2: one completion pulse per frame
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4: a high majority during the start bit returns to idle
  a_r4_start_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == ST_START && cnt_q == mid_hi && maj) |=>
      (state_q == ST_IDLE && !start_ok_o));
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end

  always_ff @(posedge clk_i)
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;

  // R10: flush empties the buffer
  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  // R7: occupancy never exceeds the depth
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_rx_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             rx_en_i,
  input  logic             dbl_speed_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [3:0]       char_bits_i,
  input  logic [1:0]       par_mode_i,
  input  logic             mpc_en_i,
  input  logic             rx_irq_en_i,
  input  logic             rd_lo_i,
  output logic [7:0]       rdata_o,
  output logic             bit9_o,
  output logic             frame_err_o,
  output logic             parity_err_o,
  output logic             overrun_o,
  output logic             rx_done_o,
  output logic             irq_o
);
  localparam int unsigned CHAR_W = $bits(rx_char_t);

  logic     rxd, tick, start_ok, deser_done, accept;
  logic     fifo_push, fifo_empty, fifo_full;
  logic     pend_v_q;
  rx_char_t deser_char, pend_q, head;

  sio_rx_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rxd)
  );

  sio_rx_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .en_i(rx_en_i), .div_i, .tick_o(tick)
  );

  sio_rx_deser i_deser (
    .clk_i, .rst_ni,
    .en_i       (rx_en_i),
    .tick_i     (tick),
    .rxd_i      (rxd),
    .dbl_i      (dbl_speed_i),
    .char_bits_i,
    .par_mode_i,
    .start_ok_o (start_ok),
    .done_o     (deser_done),
    .char_o     (deser_char)
  );

  // address filter: in multiprocessor mode only ninth-bit-set frames pass
  assign accept    = deser_done && !(mpc_en_i && !deser_char.data[DATA_W-1]);
  assign fifo_push = pend_v_q && !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (!rx_en_i) begin
      pend_v_q <= 1'b0;
    end else begin
      if (fifo_push) pend_v_q <= 1'b0;
      if (accept && (!pend_v_q || fifo_push)) begin
        pend_v_q <= 1'b1;
        pend_q   <= deser_char;
      end
      if (start_ok && pend_v_q && fifo_full && !fifo_push) pend_q.ovr <= 1'b1;
    end

  sio_rx_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .flush_i (!rx_en_i),
    .push_i  (fifo_push),
    .wdata_i (pend_q),
    .pop_i   (rd_lo_i),
    .rdata_o (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign rdata_o      = head.data[7:0];
  assign bit9_o       = head.data[8];
  assign frame_err_o  = head.fe;
  assign parity_err_o = head.pe;
  assign overrun_o    = head.ovr;
  assign rx_done_o    = !fifo_empty;
  assign irq_o        = rx_done_o && rx_irq_en_i;

  // R11: receive-complete only rises after a write into the buffer
  a_r11_done_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $past(fifo_push));
  // R9: a filtered frame leaves the holding register untouched
  a_r9_mpc_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && deser_done && mpc_en_i && !deser_char.data[8]) |=> $stable(pend_q));
  // R8: overrun only marks a held character behind a full buffer
  a_r8_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q.ovr) |-> $past(fifo_full && pend_v_q && start_ok));
endmodule

// File: tb/test_sio_rx.sv
`timescale 1ns/1ps
module test_sio_rx;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rx = 1'b1, rx_en = 1'b0, dbl = 1'b0, mpc = 1'b0, irq_en = 1'b0, rd_lo = 1'b0;
  logic [7:0] div = '0;
  logic [3:0] nbits = 4'd8;
  logic [1:0] pmode = 2'b00;
  logic [7:0] rdata;
  logic       bit9, fe, pe, ovr, done, irq;

  int   n_chk = 0, n_fail = 0, bit_clks = 16;
  bit   mon_on = 1'b0, finished = 1'b0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sio_rx i_sio_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_en_i(rx_en), .dbl_speed_i(dbl),
    .div_i(div), .char_bits_i(nbits), .par_mode_i(pmode), .mpc_en_i(mpc),
    .rx_irq_en_i(irq_en), .rd_lo_i(rd_lo), .rdata_o(rdata), .bit9_o(bit9),
    .frame_err_o(fe), .parity_err_o(pe), .overrun_o(ovr), .rx_done_o(done), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void set_rate();
    bit_clks = (dbl ? 8 : 16) * (int'(div) + 1);
  endfunction

  task automatic drive_bit(input logic v);
    rx = v;
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit bad_par, input bit stop_v,
                      input bit keep, input bit ovr_e, input string tag);
    logic [8:0] dm;
    logic       p;
    dm = d & ((9'h1 << nbits) - 9'h1);
    if (keep) begin
      exp_q.push_back({dm[8], dm[7:0], ~stop_v, pmode[1] & bad_par, ovr_e});
      tag_q.push_back(tag);
    end
    drive_bit(1'b0);
    for (int i = 0; i < int'(nbits); i++) drive_bit(dm[i]);
    if (pmode[1]) begin
      p = (^dm) ^ pmode[0] ^ bad_par;
      drive_bit(p);
    end
    drive_bit(stop_v);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    rd_lo = 1'b0;
    if (mon_on && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected character", {bit9, rdata, fe, pe, ovr}, 0);
      end else begin
        logic [11:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({bit9, rdata, fe, pe, ovr} == e, t, {bit9, rdata, fe, pe, ovr}, e);
      end
      rd_lo = 1'b1;
    end
  end

  task automatic drain(input string tag);
    int t = 0;
    while (exp_q.size() != 0 && t < bit_clks * 60) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !done, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    irq_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 rx_done after reset", done, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    irq_en = 1'b0;
    rx_en = 1'b1;
    set_rate();
    mon_on = 1'b1;
    repeat (40) @(negedge clk);

    // R2 basic 8-bit frames, R7 order
    send(9'h0A5, 0, 1, 1, 0, "R2 8-bit A5");
    send(9'h03C, 0, 1, 1, 0, "R7 8-bit 3C order");
    nbits = 4'd5;
    send(9'h1FF, 0, 1, 1, 0, "R2 5-bit masked");
    nbits = 4'd7;
    send(9'h055, 0, 1, 1, 0, "R2 7-bit 55");
    drain("R2 drain");

    // R5 parity
    nbits = 4'd8;
    pmode = 2'b10;
    send(9'h0C3, 0, 1, 1, 0, "R5 even good");
    send(9'h0C2, 1, 1, 1, 0, "R5 even bad");
    pmode = 2'b11;
    send(9'h071, 0, 1, 1, 0, "R5 odd good");
    send(9'h070, 1, 1, 1, 0, "R5 odd bad");
    pmode = 2'b01;
    send(9'h011, 0, 1, 1, 0, "R5 mode 01 no parity");
    pmode = 2'b00;
    drain("R5 drain");

    // R6 frame error
    send(9'h0E7, 0, 0, 1, 0, "R6 stop low");
    send(9'h018, 0, 1, 1, 0, "R6 stop high after error");
    drain("R6 drain");

    // R3 rates
    dbl = 1'b1; set_rate();
    send(9'h09A, 0, 1, 1, 0, "R3 8x sampling");
    send(9'h065, 0, 1, 1, 0, "R3 8x sampling 2");
    dbl = 1'b0; div = 8'd2; set_rate();
    send(9'h0D2, 0, 1, 1, 0, "R3 divisor 2");
    dbl = 1'b1; set_rate();
    send(9'h02D, 0, 1, 1, 0, "R3 divisor 2 8x");
    drain("R3 drain");
    dbl = 1'b0; div = '0; set_rate();

    // R4 glitch rejection
    mon_on = 1'b0;
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (3 * bit_clks) @(negedge clk);
    chk(done == 1'b0, "R4 glitch ignored", done, 0);
    mon_on = 1'b1;
    send(9'h081, 0, 1, 1, 0, "R4 frame after glitch");
    drain("R4 drain");

    // R12 ninth bit read without pop
    nbits = 4'd9;
    mon_on = 1'b0;
    send(9'h155, 0, 1, 1, 0, "R12 9-bit 155");
    repeat (3) @(negedge clk);
    chk(bit9 == 1'b1 && done, "R12 ninth bit visible", {done, bit9}, 2'b11);
    repeat (5) @(negedge clk);
    chk(bit9 == 1'b1 && done && rdata == 8'h55, "R12 no pop on sampling", {done, bit9, rdata}, {2'b11, 8'h55});
    mon_on = 1'b1;
    drain("R12 drain");

    // R9 multiprocessor filter
    mpc = 1'b1;
    send(9'h0AA, 0, 1, 0, 0, "R9 data dropped");
    send(9'h1C3, 0, 1, 1, 0, "R9 address kept");
    send(9'h011, 0, 1, 0, 0, "R9 data dropped 2");
    drain("R9 drain");
    mpc = 1'b0;
    nbits = 4'd8;

    // R8 overrun
    mon_on = 1'b0;
    send(9'h001, 0, 1, 1, 0, "R8 first clean");
    send(9'h002, 0, 1, 1, 0, "R8 second clean");
    send(9'h003, 0, 1, 1, 1, "R8 held char overrun");
    send(9'h004, 0, 1, 0, 0, "R8 lost");
    chk(done == 1'b1, "R8 buffer full", done, 1);
    mon_on = 1'b1;
    drain("R8 drain no lost frame");

    // R10 flush, R11 irq
    mon_on = 1'b0;
    send(9'h0F0, 0, 1, 0, 0, "R10 flushed 1");
    send(9'h00F, 0, 1, 0, 0, "R10 flushed 2");
    irq_en = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && irq == 1'b0, "R11 irq masked", {done, irq}, 2'b10);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq enabled", irq, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && irq == 1'b0, "R10 flush empties", {done, irq}, 2'b00);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    chk(done == 1'b0, "R10 stays empty", done, 0);
    mon_on = 1'b1;
    send(9'h05A, 0, 1, 1, 0, "R10 receive after flush");
    drain("R10 drain");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule